// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Retransmit

This block is a single-clock FIFO for 18-bit words with a parameterised power-of-two depth (2048 words by default). The level of the mode pin while master reset is low picks one of two ways of reading. In standard mode, each word needs its own read request, and the status pins act as empty and full flags. In fall-through mode, the oldest word moves to the output on its own, and the status pins act as output-ready and input-ready flags. A half-full flag is driven in both modes.

Two active-low resets are provided, and both clear the pointers and the output register as soon as they go low. The master reset also samples the mode pin. The partial reset keeps the mode that is already latched.

The retransmit input rewinds reads to memory location zero, so that data already read can be replayed. Reads restart once a short setup has completed, and the flag timing during setup depends on the mode. Retransmit is meant for a run of fewer than DEPTH writes since the last reset.

Top module: `dmfifo_rt`

## Requirements
- R1: While `mrst_n` is low, `dout` is all zeroes and both pointers return to location zero. After a master reset in standard mode, `stat_e_n` is 0, `stat_f_n` is 1 and `half_n` is 1.
- R2: The level of `mode_si` sampled on clock edges while `mrst_n` is low selects the mode: 0 is standard and 1 is fall-through. After `mrst_n` is high, `mode_si` has no effect.
- R3: In standard mode, `dout` changes only on an edge where `rd_n` is 0 and at least one word is stored. On that edge `dout` takes the oldest stored word, so words leave in write order.
- R4: In standard mode, `stat_e_n` is 0 exactly when no word is stored, and `stat_f_n` is 0 exactly when DEPTH words are stored. Both flags follow the edge on which the write or read takes effect.
- R5: In fall-through mode, a word written to an empty FIFO appears on `dout` one edge after its write edge, with `rd_n` held at 1. `stat_e_n` is 0 while `dout` holds a valid word. Each edge with `rd_n` at 0 replaces the word with the next one, or clears `stat_e_n` when none is left.
- R6: In fall-through mode, the capacity is DEPTH+1 words, counting the output word. `stat_f_n` is 1 exactly when the memory holds DEPTH words besides the output word. After a reset, `stat_e_n` is 1 and `stat_f_n` is 0.
- R7: `half_n` is 0 exactly when the occupancy is above DEPTH/2. In fall-through mode the occupancy includes a valid output word.
- R8: A write while full is ignored and does not move the write pointer. A read while empty leaves `dout` unchanged.
- R9: While `prst_n` is low, `dout` is zero and both pointers return to zero. The latched mode is kept, and after release the flags show that mode's reset values.
- R10: In standard mode, an edge with `rt_n` at 0 starts retransmit setup. `rd_n` and `wr_n` must be 1 on that edge. The read pointer goes to location zero and `stat_e_n` goes to 0. `stat_e_n` stays 0 until the third edge with `rt_n` at 1. After that edge each word is read again from location zero, one `rd_n` request per word.
- R11: In fall-through mode, the edge that starts retransmit sets `stat_e_n` to 1. After the third edge with `rt_n` at 1, the next edge puts the word at location zero on `dout` and sets `stat_e_n` to 0, with no read request. Later words need `rd_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| mrst_n | input | 1 | Master reset, active low, asynchronous clear; samples mode_si |
| prst_n | input | 1 | Partial reset, active low, asynchronous clear; keeps the mode |
| mode_si | input | 1 | Mode select, sampled only during master reset (0 standard, 1 fall-through) |
| din | input | 18 | Write data |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Retransmit request, active low |
| dout | output | 18 | Output register |
| stat_e_n | output | 1 | Empty flag (standard) or output-ready flag (fall-through), active low |
| stat_f_n | output | 1 | Full flag (standard) or input-ready flag (fall-through), active low |
| half_n | output | 1 | Half-full flag, active low |

## Verification
A wrong occupancy count shows on the first edge after the faulty update. It appears as a flag changing one word early or late while the FIFO is filled or drained, and the bench checks the flags after every word. A read pointer off by one shows on the first word delivered afterwards, because every `dout` value is compared with the value written. A fault in the retransmit sequencer shows as a flag that releases one edge too early or too late. It can also show as a replay that does not start at location zero.

// File: rtl/dmfifo_pkg.sv
// Shared types for the dual-mode FIFO.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package dmfifo_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // Rising edges with retransmit released before setup ends
    localparam int unsigned RT_EDGES = 3;
endpackage

// File: rtl/dmfifo_ram.sv
// Storage array: one synchronous write port and one combinational read port.
// Assumes: the controller never writes and reads the same entry in a way
// that needs write-through; the output register sits in the controller.
module dmfifo_ram #(
    parameter int unsigned WIDTH = 18,
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store a word on an accepted write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the word at the read pointer
    always_comb begin
        rdata = mem[raddr];
    end
endmodule

// File: rtl/dmfifo_ctrl.sv
// Pointer, occupancy, output register and retransmit sequencing.
// Assumes: DEPTH is a power of two; rst_n is the AND of both resets and
// clears state asynchronously; rd_n and wr_n are high while rt_n is low.
module dmfifo_ctrl
    import dmfifo_pkg::*;
#(
    parameter int unsigned WIDTH = 18,
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fifo_mode_e       mode,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rt_n,
    output logic             ram_we,
    output logic [AW-1:0]    ram_waddr,
    output logic [AW-1:0]    ram_raddr,
    input  logic [WIDTH-1:0] ram_rdata,
    output logic [WIDTH-1:0] dout,
    output logic             out_valid,
    output logic             rt_busy,
    output logic [CW-1:0]    count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [1:0]    RT_LAST  = 2'(RT_EDGES - 1);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [1:0]    rt_cnt;
    logic          fwft;
    logic          rt_go;
    logic          active;
    logic          has_word;
    logic          wr_ok;
    logic          load;
    logic          drop;

    // Decode the operations this edge will perform
    always_comb begin
        fwft     = (mode == MODE_FWFT);
        rt_go    = !rt_n;
        active   = rt_n && !rt_busy;
        has_word = (count != '0);
        wr_ok    = !wr_n && active && (count != FULL_CNT);
        load     = active && has_word && (fwft ? (!out_valid || !rd_n) : !rd_n);
        drop     = fwft && active && out_valid && !rd_n && !has_word;
    end

    assign ram_we    = wr_ok;
    assign ram_waddr = wr_ptr;
    assign ram_raddr = rd_ptr;

    // Advance the pointers and occupancy, or rewind on retransmit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (rt_go) begin
            rd_ptr <= '0;
            count  <= {1'b0, wr_ptr};
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (load)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(wr_ok) - CW'(load);
        end
    end

    // Output register and its valid bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout      <= '0;
            out_valid <= 1'b0;
        end else begin
            if (load) dout <= ram_rdata;
            if (rt_go || drop) out_valid <= 1'b0;
            else if (load && fwft) out_valid <= 1'b1;
        end
    end

    // Retransmit setup: hold while rt_n is low, then count release edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt_busy <= 1'b0;
            rt_cnt  <= '0;
        end else if (rt_go) begin
            rt_busy <= 1'b1;
            rt_cnt  <= '0;
        end else if (rt_busy) begin
            if (rt_cnt == RT_LAST) rt_busy <= 1'b0;
            else rt_cnt <= rt_cnt + 1'b1;
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R8
    full_write_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && !wr_n) |=> wr_ptr == $past(wr_ptr));

    // R4
    ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        AW'(wr_ptr - rd_ptr) == count[AW-1:0]);

    // R10
    rt_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_n |=> (rt_busy && rd_ptr == '0 && count == {1'b0, $past(wr_ptr)}));

    // R5
    fwft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && out_valid && rd_n && rt_n && !rt_busy) |=> (out_valid && $stable(dout)));

    // R11
    rt_fwft_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && !rt_n) |=> !out_valid);
endmodule

// File: rtl/dmfifo_rt.sv
// Top of the dual-mode FIFO: latches the mode during master reset, merges
// the two resets and maps internal state onto the mode-dependent flags.
// Assumes: DEPTH is a power of two; mode_si is held during master reset.
module dmfifo_rt
    import dmfifo_pkg::*;
#(
    parameter int unsigned WIDTH = 18,
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             mode_si,
    input  logic [WIDTH-1:0] din,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rt_n,
    output logic [WIDTH-1:0] dout,
    output logic             stat_e_n,
    output logic             stat_f_n,
    output logic             half_n
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    fifo_mode_e       mode;
    logic             rst_n;
    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    logic [AW-1:0]    ram_raddr;
    logic [WIDTH-1:0] ram_rdata;
    logic             out_valid;
    logic             rt_busy;
    logic [CW-1:0]    count;
    logic [CW-1:0]    occ;

    assign rst_n = mrst_n & prst_n;

    // Capture the mode pin on every edge of a master reset
    always_ff @(posedge clk) begin
        if (!mrst_n) mode <= fifo_mode_e'(mode_si);
    end

    dmfifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (din),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    dmfifo_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .rt_n      (rt_n),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_raddr (ram_raddr),
        .ram_rdata (ram_rdata),
        .dout      (dout),
        .out_valid (out_valid),
        .rt_busy   (rt_busy),
        .count     (count)
    );

    // Map state onto the flags of the latched mode
    always_comb begin
        occ = count + CW'((mode == MODE_FWFT) && out_valid);
        if (mode == MODE_FWFT) begin
            stat_e_n = !out_valid;
            stat_f_n = (count == FULL_CNT);
        end else begin
            stat_e_n = !rt_busy && (count != '0);
            stat_f_n = (count != FULL_CNT);
        end
        half_n = !(occ > HALF_CNT);
    end

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(mode));
endmodule

// File: tb/dmfifo_rt_test.sv
// Bench: fills and drains a 16-deep FIFO in both modes, checks every flag
// after every word, and replays data with retransmit.
module dmfifo_rt_test;
    localparam int DEPTH = 16;
    localparam int WIDTH = 18;

    logic             clk = 1'b0;
    logic             mrst_n = 1'b1;
    logic             prst_n = 1'b1;
    logic             mode_si = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic             wr_n = 1'b1;
    logic             rd_n = 1'b1;
    logic             rt_n = 1'b1;
    logic [WIDTH-1:0] dout;
    logic             stat_e_n;
    logic             stat_f_n;
    logic             half_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmfifo_rt #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_si(mode_si),
        .din(din), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .dout(dout), .stat_e_n(stat_e_n), .stat_f_n(stat_f_n), .half_n(half_n)
    );

    function automatic logic [WIDTH-1:0] pat(int i);
        return WIDTH'(i * 2731 + 17) ^ WIDTH'(i << 9);
    endfunction

    task automatic chk(string req, string what, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_mrst(logic m);
        @(negedge clk);
        mode_si = m;
        mrst_n = 1'b0;
        step();
        step();
        mrst_n = 1'b1;
        mode_si = ~m;   // R2: later levels on the pin must be ignored
        step();
    endtask

    task automatic do_prst(string req);
        prst_n = 1'b0;
        #1;
        chk(req, "dout during partial reset", dout, '0);
        @(negedge clk);
        step();
        prst_n = 1'b1;
        step();
    endtask

    task automatic wr(logic [WIDTH-1:0] d);
        din = d;
        wr_n = 1'b0;
        step();
        wr_n = 1'b1;
    endtask

    task automatic rd();
        rd_n = 1'b0;
        step();
        rd_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // ---------------- standard mode ----------------
        do_mrst(1'b0);
        chk("R1", "dout after reset", dout, '0);
        chk("R1", "empty_n after reset", WIDTH'(stat_e_n), 0);
        chk("R1", "full_n after reset", WIDTH'(stat_f_n), 1);
        chk("R1", "half_n after reset", WIDTH'(half_n), 1);

        for (int i = 0; i < DEPTH; i++) begin
            wr(pat(i));
            chk("R4", "empty_n while filling", WIDTH'(stat_e_n), 1);
            chk("R4", "full_n while filling", WIDTH'(stat_f_n), WIDTH'(i + 1 < DEPTH));
            chk("R7", "half_n while filling", WIDTH'(half_n), WIDTH'(!(i + 1 > DEPTH / 2)));
        end
        step();
        chk("R3", "dout unchanged without read", dout, '0);
        chk("R2", "standard flags kept with mode_si high", WIDTH'(stat_e_n), 1);

        wr('1);
        chk("R8", "full_n after write while full", WIDTH'(stat_f_n), 0);

        for (int i = 0; i < DEPTH; i++) begin
            rd();
            chk("R3", "dout in write order", dout, pat(i));
            chk("R4", "empty_n while draining", WIDTH'(stat_e_n), WIDTH'(i + 1 < DEPTH));
            chk("R7", "half_n while draining", WIDTH'(half_n), WIDTH'(!(DEPTH - i - 1 > DEPTH / 2)));
        end
        rd();
        chk("R8", "dout after read while empty", dout, pat(DEPTH - 1));
        chk("R8", "empty_n after read while empty", WIDTH'(stat_e_n), 0);

        wr(pat(7));
        do_prst("R9");
        chk("R9", "dout after partial reset", dout, '0);
        chk("R9", "empty_n after partial reset (standard kept)", WIDTH'(stat_e_n), 0);
        chk("R9", "full_n after partial reset", WIDTH'(stat_f_n), 1);

        for (int i = 0; i < 5; i++) wr(pat(20 + i));
        rd();
        chk("R3", "first word before retransmit", dout, pat(20));
        rd();
        chk("R3", "second word before retransmit", dout, pat(21));
        rt_n = 1'b0;
        step();
        rt_n = 1'b1;
        chk("R10", "empty_n at setup start", WIDTH'(stat_e_n), 0);
        step();
        chk("R10", "empty_n after release edge 1", WIDTH'(stat_e_n), 0);
        step();
        chk("R10", "empty_n after release edge 2", WIDTH'(stat_e_n), 0);
        step();
        chk("R10", "empty_n after release edge 3", WIDTH'(stat_e_n), 1);
        chk("R10", "dout not advanced by setup", dout, pat(21));
        for (int i = 0; i < 5; i++) begin
            rd();
            chk("R10", "replayed word", dout, pat(20 + i));
        end
        chk("R10", "empty_n after replay", WIDTH'(stat_e_n), 0);

        // ---------------- fall-through mode ----------------
        do_mrst(1'b1);
        chk("R6", "ready_n after reset", WIDTH'(stat_e_n), 1);
        chk("R6", "in_ready_n after reset", WIDTH'(stat_f_n), 0);
        chk("R1", "dout after fall-through reset", dout, '0);
        chk("R7", "half_n after fall-through reset", WIDTH'(half_n), 1);

        for (int j = 1; j <= DEPTH + 1; j++) begin
            wr(pat(40 + j - 1));
            chk("R5", "ready_n while filling", WIDTH'(stat_e_n), WIDTH'(j == 1));
            chk("R5", "dout falls through", dout, (j == 1) ? '0 : pat(40));
            chk("R6", "in_ready_n while filling", WIDTH'(stat_f_n), WIDTH'(j == DEPTH + 1));
            chk("R7", "half_n while filling", WIDTH'(half_n), WIDTH'(!(j > DEPTH / 2)));
        end
        wr('1);
        chk("R8", "in_ready_n after write while full", WIDTH'(stat_f_n), 1);

        for (int r = 1; r <= DEPTH + 1; r++) begin
            rd();
            chk("R5", "ready_n while draining", WIDTH'(stat_e_n), WIDTH'(r == DEPTH + 1));
            if (r <= DEPTH) chk("R5", "dout while draining", dout, pat(40 + r));
            chk("R6", "in_ready_n while draining", WIDTH'(stat_f_n), 0);
            chk("R7", "half_n while draining", WIDTH'(half_n), WIDTH'(!(DEPTH + 1 - r > DEPTH / 2)));
        end
        rd();
        chk("R8", "dout after read while empty", dout, pat(40 + DEPTH));

        do_prst("R9");
        chk("R9", "ready_n after partial reset (fall-through kept)", WIDTH'(stat_e_n), 1);
        chk("R9", "in_ready_n after partial reset", WIDTH'(stat_f_n), 0);
        chk("R9", "dout after partial reset", dout, '0);

        for (int i = 0; i < 4; i++) wr(pat(60 + i));
        step();
        chk("R5", "first word without read", dout, pat(60));
        rd();
        rd();
        chk("R5", "third word after two reads", dout, pat(62));
        rt_n = 1'b0;
        step();
        rt_n = 1'b1;
        chk("R11", "ready_n at setup start", WIDTH'(stat_e_n), 1);
        for (int k = 1; k <= 3; k++) begin
            step();
            chk("R11", "ready_n during release edges", WIDTH'(stat_e_n), 1);
        end
        step();
        chk("R11", "ready_n after setup", WIDTH'(stat_e_n), 0);
        chk("R11", "location zero on dout", dout, pat(60));
        for (int i = 1; i < 4; i++) begin
            rd();
            chk("R11", "replayed word", dout, pat(60 + i));
        end
        rd();
        chk("R11", "ready_n after replay", WIDTH'(stat_e_n), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule